// File: doc/BRIEF.md
# Byte-Serial Preset Up/Down Counter

This block is one channel of an up/down position counter whose 24-bit state is reached by a host through an 8-bit byte port. The host never writes the live count directly. It fills a preset register one byte at a time and then issues a command that copies the preset into the counter. To read the count, it issues a snapshot command that freezes the count into an output latch. It then pulls the latch out one byte at a time. A single byte pointer serves both directions and steps on every data access.

Count pulses and their direction come from an external quadrature or pulse decoder. A separate index input can reload the counter from the preset. Sticky flags record up-wraps (carry), down-wraps (borrow) and input noise. The host reads these flags, together with the last accepted direction, from a status byte. The host side is a plain strobe interface that accepts one access per cycle. There is no back-pressure: every strobe is taken in the cycle it is presented, and a read returns its byte combinationally in that same cycle.

Top module: `byte_preset_counter`

## Requirements
- R1: After reset the count, preset, output latch, byte pointer and all flags are zero, the status byte reads 0x00, and counting is disabled.
- R2: A control write of 0x01 returns the byte pointer to byte 0. A control write of 0x11 returns the pointer to byte 0 and copies the live count into the output latch.
- R3: Each data write, and each data read not accompanied by a write, advances the single shared byte pointer. After byte 2 the pointer wraps to byte 0.
- R4: A data read returns the latch byte selected by the pointer, least significant first. The latch does not follow later counting until the next snapshot.
- R5: Data writes store into the preset byte selected by the pointer. Writing the preset does not change the count.
- R6: A control write of 0x08 copies the preset into the counter. This load has priority over an index reload or a count pulse in the same cycle.
- R7: A control write whose upper three bits are 010 loads a 2-bit configuration from bits 1:0. Bit 0 enables counting. While bit 0 is clear, count pulses leave the count unchanged.
- R8: An enabled up pulse at 0xFFFFFF wraps the count to 0 and sets carry (status bit 1). An enabled down pulse at 0 wraps it to 0xFFFFFF and sets borrow (status bit 0). Both flags stay set until cleared.
- R9: A control write of 0x02 or 0x04 clears carry and borrow. A control write of 0x06 clears the error flag. A flag being set in the same cycle as its clear stays set.
- R10: A pulse on noise_err sets the sticky error flag, which is reported in status bit 4.
- R11: Status bit 5 holds the direction of the most recent enabled count pulse, with 1 meaning up.
- R12: An index pulse loads the preset into the counter when configuration bit 1 is 0 (active-low enable). The pulse is ignored when that bit is 1.
- R13: Any other control byte changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 selects the data byte port, 1 selects the control/status port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Latch byte (data port) or status byte (control port) |
| cnt_pulse | input | 1 | One count event from the decoder |
| cnt_up | input | 1 | Direction of the count event, 1 = up |
| index_pulse | input | 1 | Index event |
| noise_err | input | 1 | Noise detected on the count inputs |

## Verification
The bench targets several corner cases.
- A fourth read after a snapshot must return byte 0 again. A pointer that did not wrap would return stale or undefined data.
- A read that follows a single write must return latch byte 1. A design with separate read and write pointers would return byte 0.
- The count must wrap in both directions at the 24-bit edges. A wrong flag or a non-sticky flag shows up in the status byte.
- A load, an index reload and a count pulse arrive in the same cycle. A wrong priority leaves the count off by one or at the wrong preset.
- Unknown control codes and disabled counting must leave the state untouched. A decoder that is too loose would corrupt the pointer, flags or count.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_PTR_RST,
    CMD_SNAP,
    CMD_LOAD,
    CMD_CLR_BC,
    CMD_CLR_ERR,
    CMD_IOCFG
  } bpc_cmd_e;

  localparam int unsigned STS_BORROW = 0;
  localparam int unsigned STS_CARRY  = 1;
  localparam int unsigned STS_ERR    = 4;
  localparam int unsigned STS_DIR    = 5;
endpackage

// File: rtl/bpc_cmd_decode.sv
module bpc_cmd_decode
  import bpc_pkg::*;
(
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] code,
  output bpc_cmd_e          cmd,
  output logic [1:0]        cfg
);
  always_comb begin
    cmd = CMD_NONE;
    cfg = code[1:0];
    if (ctrl_wr) begin
      if (code[7:5] == 3'b010) begin
        cmd = CMD_IOCFG;
      end else begin
        case (code)
          8'h01:        cmd = CMD_PTR_RST;
          8'h11:        cmd = CMD_SNAP;
          8'h08:        cmd = CMD_LOAD;
          8'h02, 8'h04: cmd = CMD_CLR_BC;
          8'h06:        cmd = CMD_CLR_ERR;
          default:      cmd = CMD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bpc_byte_ptr.sv
module bpc_byte_ptr #(
  parameter int unsigned NBYTES = 3,
  localparam int unsigned PW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clr) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr == '0);
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && ptr == LAST) |=> ptr == '0);
endmodule

// File: rtl/bpc_byte_regs.sv
module bpc_byte_regs
  import bpc_pkg::*;
#(
  parameter int unsigned NBYTES = 3,
  localparam int unsigned PW = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int unsigned CW = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_wr,
  input  logic [PW-1:0]     ptr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              snap,
  input  logic [CW-1:0]     count_in,
  output logic [CW-1:0]     preset,
  output logic [BYTE_W-1:0] latch_byte
);
  logic [CW-1:0] latch_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        preset[g*BYTE_W +: BYTE_W]  <= '0;
        latch_q[g*BYTE_W +: BYTE_W] <= '0;
      end else begin
        if (byte_wr && ptr == PW'(g)) preset[g*BYTE_W +: BYTE_W] <= wbyte;
        if (snap) latch_q[g*BYTE_W +: BYTE_W] <= count_in[g*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    latch_byte = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (ptr == PW'(i)) latch_byte = latch_q[i*BYTE_W +: BYTE_W];
    end
  end

  p_snap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> latch_q == $past(count_in));
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(latch_q));
endmodule

// File: rtl/bpc_count_core.sv
module bpc_count_core #(
  parameter int unsigned CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          index_hit,
  input  logic [CW-1:0] preset,
  input  logic          cnt_pulse,
  input  logic          cnt_up,
  input  logic          cnt_en,
  input  logic          noise,
  input  logic          clr_bc,
  input  logic          clr_err,
  output logic [CW-1:0] count,
  output logic          carry,
  output logic          borrow,
  output logic          err,
  output logic          dir
);
  localparam logic [CW-1:0] ALL_ONES = '1;

  logic take_preset, stepping, wrap_up, wrap_dn;

  always_comb begin
    take_preset = load | index_hit;
    stepping    = cnt_pulse & cnt_en & ~take_preset;
    wrap_up     = stepping & cnt_up & (count == ALL_ONES);
    wrap_dn     = stepping & ~cnt_up & (count == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      carry  <= 1'b0;
      borrow <= 1'b0;
      err    <= 1'b0;
      dir    <= 1'b0;
    end else begin
      if (take_preset)   count <= preset;
      else if (stepping) count <= cnt_up ? count + 1'b1 : count - 1'b1;
      carry  <= (carry & ~clr_bc) | wrap_up;
      borrow <= (borrow & ~clr_bc) | wrap_dn;
      err    <= (err & ~clr_err) | noise;
      if (cnt_pulse && cnt_en) dir <= cnt_up;
    end
  end

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(preset));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load && !index_hit) |=> $stable(count));
  p_carry_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && cnt_en && cnt_up && !load && !index_hit && count == ALL_ONES)
      |=> (carry && count == '0));
  p_borrow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (borrow && !clr_bc) |=> borrow);
  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    noise |=> err);
endmodule

// File: rtl/byte_preset_counter.sv
module byte_preset_counter
  import bpc_pkg::*;
#(
  parameter int unsigned NBYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              cnt_pulse,
  input  logic              cnt_up,
  input  logic              index_pulse,
  input  logic              noise_err
);
  localparam int unsigned PW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int unsigned CW = NBYTES * BYTE_W;

  bpc_cmd_e          cmd;
  logic [1:0]        cfg_new, cfg_q;
  logic [PW-1:0]     ptr;
  logic              data_wr, data_step;
  logic [CW-1:0]     preset, count;
  logic [BYTE_W-1:0] latch_byte, status;
  logic              carry, borrow, err, dir;

  bpc_cmd_decode u_dec (
    .ctrl_wr (host_wr & host_sel),
    .code    (host_wdata),
    .cmd     (cmd),
    .cfg     (cfg_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                cfg_q <= 2'b00;
    else if (cmd == CMD_IOCFG) cfg_q <= cfg_new;
  end

  always_comb begin
    data_wr   = host_wr & ~host_sel;
    data_step = data_wr | (host_rd & ~host_wr & ~host_sel);
  end

  bpc_byte_ptr #(.NBYTES(NBYTES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cmd == CMD_PTR_RST || cmd == CMD_SNAP),
    .step  (data_step),
    .ptr   (ptr)
  );

  bpc_byte_regs #(.NBYTES(NBYTES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_wr    (data_wr),
    .ptr        (ptr),
    .wbyte      (host_wdata),
    .snap       (cmd == CMD_SNAP),
    .count_in   (count),
    .preset     (preset),
    .latch_byte (latch_byte)
  );

  bpc_count_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd == CMD_LOAD),
    .index_hit (index_pulse & ~cfg_q[1]),
    .preset    (preset),
    .cnt_pulse (cnt_pulse),
    .cnt_up    (cnt_up),
    .cnt_en    (cfg_q[0]),
    .noise     (noise_err),
    .clr_bc    (cmd == CMD_CLR_BC),
    .clr_err   (cmd == CMD_CLR_ERR),
    .count     (count),
    .carry     (carry),
    .borrow    (borrow),
    .err       (err),
    .dir       (dir)
  );

  always_comb begin
    status             = '0;
    status[STS_BORROW] = borrow;
    status[STS_CARRY]  = carry;
    status[STS_ERR]    = err;
    status[STS_DIR]    = dir;
    host_rdata         = host_sel ? status : latch_byte;
  end

  p_cfg_unknown_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && cmd == CMD_NONE) |=> $stable(cfg_q));
  p_index_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (index_pulse && cfg_q[1] && !cfg_q[0] && cmd != CMD_LOAD) |=> $stable(count));
endmodule

// File: tb/byte_preset_counter_bench.sv
`timescale 1ns/1ps
module byte_preset_counter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_sel = 0, cnt_pulse = 0, cnt_up = 0;
  logic index_pulse = 0, noise_err = 0;
  logic [7:0] host_wdata = 0, host_rdata;

  always #4 clk = ~clk;

  byte_preset_counter u_byte_preset_counter (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [23:0] m_cnt, m_pre, m_lat;
  int m_ptr;
  bit m_c, m_b, m_e, m_d, m_en, m_idis;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rdata(bit sel);
    if (sel) return {2'b00, m_d, m_e, 2'b00, m_c, m_b};
    return m_lat[m_ptr*8 +: 8];
  endfunction

  logic [7:0] last_rd;

  task automatic step(bit wr, bit rd, bit sel, logic [7:0] wd, bit cp, bit cu,
                      bit ix, bit ne, string tag);
    bit stepping, take;
    host_wr = wr; host_rd = rd; host_sel = sel; host_wdata = wd;
    cnt_pulse = cp; cnt_up = cu; index_pulse = ix; noise_err = ne;
    #1;
    last_rd = host_rdata;
    chk(host_rdata == m_rdata(sel), tag, host_rdata, m_rdata(sel));
    @(posedge clk);
    take = (wr && sel && wd == 8'h08) || (ix && !m_idis);
    stepping = cp && m_en && !take;
    if (wr && sel && wd == 8'h11) m_lat = m_cnt;
    m_e = (m_e && !(wr && sel && wd == 8'h06)) || ne;
    if (wr && sel && (wd == 8'h02 || wd == 8'h04)) begin m_c = 0; m_b = 0; end
    if (stepping && cu && m_cnt == 24'hFFFFFF) m_c = 1;
    if (stepping && !cu && m_cnt == 24'h0) m_b = 1;
    if (cp && m_en) m_d = cu;
    if (take) m_cnt = m_pre;
    else if (stepping) m_cnt = cu ? m_cnt + 1 : m_cnt - 1;
    if (wr && sel && wd[7:5] == 3'b010) begin m_en = wd[0]; m_idis = wd[1]; end
    if (wr && !sel) m_pre[m_ptr*8 +: 8] = wd;
    if (wr && sel && (wd == 8'h01 || wd == 8'h11)) m_ptr = 0;
    else if (!sel && (wr || rd)) m_ptr = (m_ptr + 1) % 3;
    @(negedge clk);
  endtask

  task automatic ctrl(logic [7:0] c, string tag); step(1,0,1,c,0,0,0,0,tag); endtask
  task automatic dwr(logic [7:0] b, string tag); step(1,0,0,b,0,0,0,0,tag); endtask
  task automatic drd(logic [7:0] exp, string tag);
    step(0,1,0,0,0,0,0,0,tag); chk(last_rd == exp, tag, last_rd, exp);
  endtask
  task automatic srd(logic [7:0] exp, string tag);
    step(0,1,1,0,0,0,0,0,tag); chk(last_rd == exp, tag, last_rd, exp);
  endtask
  task automatic pulse(bit up, string tag); step(0,0,0,0,1,up,0,0,tag); endtask

  initial begin
    #(8*200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [14] = '{8'h01,8'h11,8'h08,8'h02,8'h04,8'h06,8'h40,
                               8'h41,8'h42,8'h43,8'h00,8'h03,8'h80,8'hFF};
    void'($urandom(32'd5150));
    m_cnt = 0; m_pre = 0; m_lat = 0; m_ptr = 0;
    m_c = 0; m_b = 0; m_e = 0; m_d = 0; m_en = 0; m_idis = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    srd(8'h00, "R1 status after reset");
    pulse(1, "R1 counting disabled");
    ctrl(8'h11, "R2 snapshot");
    drd(8'h00, "R1 latch b0"); drd(8'h00, "R1 latch b1"); drd(8'h00, "R1 latch b2");
    // R5: preset fill does not touch count
    ctrl(8'h01, "R2 ptr reset");
    dwr(8'hEF, "R5 w0"); dwr(8'hCD, "R5 w1"); dwr(8'hAB, "R5 w2");
    ctrl(8'h11, "R2 snapshot");
    drd(8'h00, "R5 count unchanged by preset write");
    // R6 load, R4 byte order, R3 wrap
    ctrl(8'h08, "R6 load");
    ctrl(8'h11, "R2 snapshot");
    drd(8'hEF, "R4 b0"); drd(8'hCD, "R4 b1"); drd(8'hAB, "R4 b2");
    drd(8'hEF, "R3 wrap to b0");
    // R7 disabled pulses ignored
    repeat (5) pulse(1, "R7 pulse disabled");
    ctrl(8'h11, "R2 snapshot");
    drd(8'hEF, "R7 count held");
    // R3 shared pointer
    ctrl(8'h01, "R2 ptr reset");
    dwr(8'h12, "R3 write b0");
    drd(8'hCD, "R3 shared pointer read b1");
    // R8 carry
    ctrl(8'h01, "R2 ptr reset");
    dwr(8'hFF, "R8 w"); dwr(8'hFF, "R8 w"); dwr(8'hFF, "R8 w");
    ctrl(8'h08, "R6 load");
    ctrl(8'h41, "R7 enable");
    pulse(1, "R8 up wrap");
    srd(8'h22, "R8 carry and R11 dir up");
    ctrl(8'h11, "R2 snapshot");
    drd(8'h00, "R8 wrapped to zero");
    pulse(1, "R8 up"); pulse(1, "R8 up");
    srd(8'h22, "R8 carry sticky");
    // R9 clear, borrow
    ctrl(8'h02, "R9 clear 02");
    srd(8'h20, "R9 carry cleared");
    ctrl(8'h08, "R6 load");
    pulse(1, "R8 up wrap"); ctrl(8'h04, "R9 clear 04");
    srd(8'h20, "R9 cleared by 04");
    pulse(0, "R8 down wrap");
    srd(8'h01, "R8 borrow and R11 dir down");
    // R10 error
    step(0,0,0,0,0,0,0,1,"R10 noise");
    srd(8'h11, "R10 error set");
    ctrl(8'h06, "R9 clear err");
    srd(8'h01, "R9 error cleared borrow kept");
    // R13 unknown codes
    ctrl(8'h03, "R13"); ctrl(8'h80, "R13"); ctrl(8'h00, "R13");
    srd(8'h01, "R13 flags unchanged");
    ctrl(8'h11, "R2 snapshot");
    drd(8'hFF, "R13 count unchanged");
    // R12 index
    ctrl(8'h01, "R2 ptr reset");
    dwr(8'h05, "R12 w"); dwr(8'h00, "R12 w"); dwr(8'h00, "R12 w");
    step(0,0,0,0,0,0,1,0,"R12 index enabled");
    ctrl(8'h11, "R2 snapshot");
    drd(8'h05, "R12 index loaded preset");
    ctrl(8'h43, "R7 cfg idx off");
    pulse(1, "R12 up");
    step(0,0,0,0,0,0,1,0,"R12 index disabled");
    ctrl(8'h11, "R2 snapshot");
    drd(8'h06, "R12 index ignored");
    // R6 priority over index and count
    ctrl(8'h41, "R7 cfg");
    step(1,0,1,8'h08,1,1,1,0,"R6 priority");
    ctrl(8'h11, "R2 snapshot");
    drd(8'h05, "R6 load wins");
    // random
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom % 10;
      bit cp = ($urandom % 3) == 0, cu = $urandom % 2;
      bit ix = ($urandom % 23) == 0, ne = ($urandom % 41) == 0;
      case (r)
        0, 1, 2: step(1,0,1,codes[$urandom % 14],cp,cu,ix,ne,"R2 R6 R9 R13 random ctrl");
        3, 4:    step(1,0,0,8'($urandom),cp,cu,ix,ne,"R3 R5 random data write");
        5, 6:    step(0,1,0,0,cp,cu,ix,ne,"R3 R4 random data read");
        default: step(0,1,1,0,cp,cu,ix,ne,"R8 R10 R11 R12 random status");
      endcase
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule